// File: doc/BRIEF.md
# Access-Security State Tracker

This block keeps the live security state of a protected memory: which of the eight password sets is open and whether it was opened with its read or its write password, which communication mode is in force, and whether configuration writes are unlocked. Compare engines elsewhere decide whether a password, an authentication, an encryption activation, a MAC or the secure code was right. Each of them sends this block a one-cycle check pulse with a pass/fail bit, and the block updates its state from that result.

A memory controller puts the password set and protection flag of the zone it is about to access on the zone inputs. It reads back combinational read and write grants. Every password set, every authentication key and the secure code has its own failure counter. Once an item has failed four times in a row, further checks of that item are dropped, so the block acts as if the attempt never happened. A session clear input models power-up and the card reset pin. It closes every grant and mode but keeps the failure counters. The asynchronous reset models a full power-on and also clears the counters.

Top module: `sec_state_tracker`

## Requirements
- R1: After the asynchronous reset, and in the cycle after `sess_clr`, no password is open, `sec_mode` is 0 (standard) and `cfg_wr_grant` is 0.
- R2: A passing password check on set S opens S with the presented kind (read or write). It replaces any set or kind open before, so at most one password is open at a time.
- R3: For a protected zone, `rd_grant` is 1 when the open set equals `zone_set` with either kind. `wr_grant` is 1 only when that set was opened with its write password. For an unprotected zone both grants are 1.
- R4: A failing password check on a set that is not locked closes any open password.
- R5: Each password set counts consecutive failures, and a pass resets its count to 0. At four failures the set is locked, and any check on it is ignored: it opens nothing and closes nothing.
- R6: A passing authentication sets `sec_mode` to 1. A failing one sets it to 0, which also drops encryption. Each of the four keys has its own lockout after four consecutive failures, and a locked key's requests leave the mode unchanged.
- R7: A passing encryption activation moves `sec_mode` to 2 only from mode 1 or 2. In mode 0 it is ignored.
- R8: A MAC mismatch in mode 1 or 2 returns `sec_mode` to 0 and raises `cmd_abort` for exactly the next cycle. A MAC match, or any MAC result in mode 0, changes nothing and raises no abort.
- R9: A secure-code check with value 0xF7620B sets `cfg_wr_grant`, and any other value clears it. The secure code has the same four-failure lockout, during which checks are ignored.
- R10: `sess_clr` leaves the failure counters intact. The asynchronous reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, clears everything |
| sess_clr | input | 1 | Synchronous session clear: closes grants and modes, keeps counters |
| pw_chk | input | 1 | Password check result pulse |
| pw_set | input | 3 | Password set the check applies to |
| pw_wr | input | 1 | 1 = write password presented, 0 = read password |
| pw_ok | input | 1 | Password compare passed |
| au_chk | input | 1 | Authentication result pulse |
| au_key | input | 2 | Key set used for the authentication |
| au_ok | input | 1 | Authentication passed |
| enc_chk | input | 1 | Encryption activation result pulse |
| enc_ok | input | 1 | Encryption activation passed |
| mac_chk | input | 1 | MAC check result pulse |
| mac_ok | input | 1 | MAC matched |
| sc_chk | input | 1 | Secure-code presentation pulse |
| sc_val | input | 24 | Presented secure code |
| zone_set | input | 3 | Password set configured for the accessed zone |
| zone_prot | input | 1 | Zone is password protected |
| rd_grant | output | 1 | Read access allowed for the zone |
| wr_grant | output | 1 | Write access allowed for the zone |
| cfg_wr_grant | output | 1 | Configuration memory writes allowed |
| sec_mode | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| cmd_abort | output | 1 | One-cycle abort after a MAC mismatch |

## Verification
The bench targets the lockout boundary. After exactly four failures a correct password must be ignored, and it must not close a password opened on another set. A design that counted from one, or that let a locked check still revoke, would show the wrong grant. It also checks that a pass midway resets the count: three failures, a pass, then three more failures must still let a pass through. A tracker that only saturates would lock that set early. It then covers encryption activation in standard mode, which a careless mode machine would accept. It checks MAC mismatches in both secure modes and in standard mode, where a wrong design either stays in a secure mode or raises a spurious abort. Finally it confirms that a session clear keeps a locked set locked, while a power-on reset unlocks it.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } sec_mode_e;
endpackage

// File: rtl/sec_try_ctr.sv
// Consecutive-failure counter for one security item; saturates at MAX_TRIES.
module sec_try_ctr #(
  parameter int MAX_TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic try_en,
  input  logic try_ok,
  output logic locked
);
  localparam int CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign locked = (cnt_q == CW'(MAX_TRIES));
  assign cnt_en = try_en & ~locked;

  always_comb begin
    cnt_d = try_ok ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sec_pw_latch.sv
// Holds the single open password: set index and kind.
module sec_pw_latch #(
  parameter int NUM_SETS = 8,
  localparam int SW = $clog2(NUM_SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  logic [SW-1:0] set_in,
  input  logic          wr_in,
  input  logic          ok_in,
  output logic          act_vld,
  output logic [SW-1:0] act_set,
  output logic          act_wr
);
  logic          vld_d, wr_d;
  logic [SW-1:0] set_d;
  logic          upd;

  assign upd = clr | go;

  always_comb begin
    vld_d = act_vld;
    set_d = act_set;
    wr_d  = act_wr;
    if (clr) begin
      vld_d = 1'b0;
      wr_d  = 1'b0;
    end else if (go) begin
      vld_d = ok_in;
      if (ok_in) begin
        set_d = set_in;
        wr_d  = wr_in;
      end else begin
        wr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld <= 1'b0;
      act_set <= '0;
      act_wr  <= 1'b0;
    end else if (upd) begin
      act_vld <= vld_d;
      act_set <= set_d;
      act_wr  <= wr_d;
    end
  end
endmodule

// File: rtl/sec_mode_fsm.sv
// Communication mode: standard / authenticated / encrypted, plus MAC abort.
module sec_mode_fsm
  import sec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      au_go,
  input  logic      au_ok,
  input  logic      enc_go,
  input  logic      enc_ok,
  input  logic      mac_chk,
  input  logic      mac_ok,
  output sec_mode_e mode_q,
  output logic      abort_q
);
  sec_mode_e mode_d;
  logic      abort_d;
  logic      mac_bad;

  assign mac_bad = mac_chk & ~mac_ok & (mode_q != MODE_STD);

  always_comb begin
    mode_d  = mode_q;
    abort_d = 1'b0;
    if (au_go) begin
      mode_d = au_ok ? MODE_AUTH : MODE_STD;
    end else if (enc_go && enc_ok && mode_q != MODE_STD) begin
      mode_d = MODE_ENC;
    end
    if (mac_bad) begin
      mode_d  = MODE_STD;
      abort_d = 1'b1;
    end
    if (clr) begin
      mode_d  = MODE_STD;
      abort_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_STD;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/sec_state_tracker.sv
module sec_state_tracker
  import sec_pkg::*;
#(
  parameter int          NUM_SETS    = 8,
  parameter int          NUM_KEYS    = 4,
  parameter int          MAX_TRIES   = 4,
  parameter int          CODE_W      = 24,
  parameter logic [23:0] SECURE_CODE = 24'hF7620B,
  localparam int SW = $clog2(NUM_SETS),
  localparam int KW = $clog2(NUM_KEYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_clr,
  input  logic              pw_chk,
  input  logic [SW-1:0]     pw_set,
  input  logic              pw_wr,
  input  logic              pw_ok,
  input  logic              au_chk,
  input  logic [KW-1:0]     au_key,
  input  logic              au_ok,
  input  logic              enc_chk,
  input  logic              enc_ok,
  input  logic              mac_chk,
  input  logic              mac_ok,
  input  logic              sc_chk,
  input  logic [CODE_W-1:0] sc_val,
  input  logic [SW-1:0]     zone_set,
  input  logic              zone_prot,
  output logic              rd_grant,
  output logic              wr_grant,
  output logic              cfg_wr_grant,
  output logic [1:0]        sec_mode,
  output logic              cmd_abort
);
  logic [NUM_SETS-1:0] pw_lock;
  logic [NUM_KEYS-1:0] au_lock;
  logic                sc_lock;
  logic                pw_go, au_go, sc_go, sc_match;

  // per-set and per-key failure counters
  for (genvar i = 0; i < NUM_SETS; i++) begin : g_pw_ctr
    sec_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .try_en(pw_chk & (pw_set == SW'(i))),
      .try_ok(pw_ok),
      .locked(pw_lock[i])
    );
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_au_ctr
    sec_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .try_en(au_chk & (au_key == KW'(k))),
      .try_ok(au_ok),
      .locked(au_lock[k])
    );
  end

  assign sc_match = (sc_val == CODE_W'(SECURE_CODE));

  sec_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_sc_ctr (
    .clk(clk), .rst_n(rst_n),
    .try_en(sc_chk),
    .try_ok(sc_match),
    .locked(sc_lock)
  );

  assign pw_go = pw_chk & ~pw_lock[pw_set];
  assign au_go = au_chk & ~au_lock[au_key];
  assign sc_go = sc_chk & ~sc_lock;

  // open password
  logic          act_vld, act_wr;
  logic [SW-1:0] act_set;

  sec_pw_latch #(.NUM_SETS(NUM_SETS)) u_pw (
    .clk(clk), .rst_n(rst_n), .clr(sess_clr), .go(pw_go),
    .set_in(pw_set), .wr_in(pw_wr), .ok_in(pw_ok),
    .act_vld(act_vld), .act_set(act_set), .act_wr(act_wr)
  );

  // communication mode
  sec_mode_e mode_q;

  sec_mode_fsm u_mode (
    .clk(clk), .rst_n(rst_n), .clr(sess_clr),
    .au_go(au_go), .au_ok(au_ok),
    .enc_go(enc_chk), .enc_ok(enc_ok),
    .mac_chk(mac_chk), .mac_ok(mac_ok),
    .mode_q(mode_q), .abort_q(cmd_abort)
  );

  // configuration write unlock
  logic cfg_q, cfg_d, cfg_en;

  assign cfg_en = sess_clr | sc_go;

  always_comb begin
    cfg_d = sess_clr ? 1'b0 : sc_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= 1'b0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // grants
  logic set_hit;

  assign set_hit      = act_vld & (act_set == zone_set);
  assign rd_grant     = ~zone_prot | set_hit;
  assign wr_grant     = ~zone_prot | (set_hit & act_wr);
  assign cfg_wr_grant = cfg_q;
  assign sec_mode     = mode_q;
endmodule

// File: rtl/sec_state_chk.sv
module sec_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sess_clr,
  input logic       mac_chk,
  input logic       mac_ok,
  input logic       rd_grant,
  input logic       wr_grant,
  input logic       cfg_wr_grant,
  input logic [1:0] sec_mode,
  input logic       cmd_abort
);
  assert_wr_has_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> rd_grant);

  assert_enc_from_auth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mode == 2'd2 && $past(sec_mode) != 2'd2) |-> $past(sec_mode) == 2'd1);

  assert_mac_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_chk && !mac_ok && sec_mode != 2'd0) |=> (sec_mode == 2'd0 && cmd_abort));

  assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);

  assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clr |=> (sec_mode == 2'd0 && !cfg_wr_grant && !cmd_abort));

  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mode != 2'd3);
endmodule

bind sec_state_tracker sec_state_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr),
  .mac_chk(mac_chk), .mac_ok(mac_ok),
  .rd_grant(rd_grant), .wr_grant(wr_grant),
  .cfg_wr_grant(cfg_wr_grant), .sec_mode(sec_mode), .cmd_abort(cmd_abort)
);

// File: tb/sim_sec_state_tracker.sv
module sim_sec_state_tracker;
  localparam logic [2:0] OP_NOP = 3'd0, OP_PWR = 3'd1, OP_PWW = 3'd2, OP_AUT = 3'd3,
                         OP_ENC = 3'd4, OP_MAC = 3'd5, OP_SCC = 3'd6, OP_CLR = 3'd7;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] arg;
    logic       ok;
    logic [2:0] zs;
    logic       ze;
    logic       rd;
    logic       wr;
    logic [1:0] md;
    logic       cfg;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    '{OP_NOP,3'd0,1'b0,3'd2,1'b1,1'b0,1'b0,2'd0,1'b0}, // 0 R1 reset state
    '{OP_NOP,3'd0,1'b0,3'd2,1'b0,1'b1,1'b1,2'd0,1'b0}, // 1 R3 unprotected
    '{OP_PWR,3'd2,1'b1,3'd2,1'b1,1'b1,1'b0,2'd0,1'b0}, // 2 R2 read pw
    '{OP_NOP,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 3 R3 other set
    '{OP_PWW,3'd2,1'b1,3'd2,1'b1,1'b1,1'b1,2'd0,1'b0}, // 4 R3 write pw
    '{OP_PWR,3'd5,1'b1,3'd2,1'b1,1'b0,1'b0,2'd0,1'b0}, // 5 R2 replaced
    '{OP_NOP,3'd0,1'b0,3'd5,1'b1,1'b1,1'b0,2'd0,1'b0}, // 6 R2
    '{OP_PWW,3'd5,1'b0,3'd5,1'b1,1'b0,1'b0,2'd0,1'b0}, // 7 R4 revoke
    '{OP_AUT,3'd1,1'b1,3'd5,1'b1,1'b0,1'b0,2'd1,1'b0}, // 8 R6
    '{OP_ENC,3'd0,1'b1,3'd5,1'b1,1'b0,1'b0,2'd2,1'b0}, // 9 R7
    '{OP_MAC,3'd0,1'b1,3'd5,1'b1,1'b0,1'b0,2'd2,1'b0}, // 10 R8 match
    '{OP_MAC,3'd0,1'b0,3'd5,1'b1,1'b0,1'b0,2'd0,1'b0}, // 11 R8 mismatch
    '{OP_ENC,3'd0,1'b1,3'd5,1'b1,1'b0,1'b0,2'd0,1'b0}, // 12 R7 ignored
    '{OP_AUT,3'd1,1'b1,3'd5,1'b1,1'b0,1'b0,2'd1,1'b0}, // 13 R6
    '{OP_AUT,3'd1,1'b0,3'd5,1'b1,1'b0,1'b0,2'd0,1'b0}, // 14 R6 fail revokes
    '{OP_SCC,3'd0,1'b1,3'd5,1'b1,1'b0,1'b0,2'd0,1'b1}, // 15 R9
    '{OP_SCC,3'd0,1'b0,3'd5,1'b1,1'b0,1'b0,2'd0,1'b0}, // 16 R9
    '{OP_SCC,3'd0,1'b1,3'd5,1'b1,1'b0,1'b0,2'd0,1'b1}, // 17 R9
    '{OP_PWR,3'd4,1'b1,3'd4,1'b1,1'b1,1'b0,2'd0,1'b1}, // 18 R2
    '{OP_CLR,3'd0,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 19 R1 clear
    '{OP_PWR,3'd3,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 20 R5
    '{OP_PWR,3'd3,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 21 R5
    '{OP_PWR,3'd3,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 22 R5
    '{OP_PWR,3'd3,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 23 R5 locked now
    '{OP_PWR,3'd6,1'b1,3'd6,1'b1,1'b1,1'b0,2'd0,1'b0}, // 24 R2
    '{OP_PWW,3'd3,1'b1,3'd6,1'b1,1'b1,1'b0,2'd0,1'b0}, // 25 R5 ignored
    '{OP_NOP,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 26 R5
    '{OP_PWR,3'd4,1'b0,3'd6,1'b1,1'b0,1'b0,2'd0,1'b0}, // 27 R4
    '{OP_PWR,3'd4,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 28 R5
    '{OP_PWR,3'd4,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 29 R5 three fails
    '{OP_PWW,3'd4,1'b1,3'd4,1'b1,1'b1,1'b1,2'd0,1'b0}, // 30 R5 pass resets
    '{OP_PWR,3'd4,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 31 R5
    '{OP_PWR,3'd4,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 32 R5
    '{OP_PWR,3'd4,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 33 R5
    '{OP_PWR,3'd4,1'b1,3'd4,1'b1,1'b1,1'b0,2'd0,1'b0}, // 34 R5 still open
    '{OP_AUT,3'd2,1'b0,3'd4,1'b1,1'b1,1'b0,2'd0,1'b0}, // 35 R6
    '{OP_AUT,3'd2,1'b0,3'd4,1'b1,1'b1,1'b0,2'd0,1'b0}, // 36 R6
    '{OP_AUT,3'd2,1'b0,3'd4,1'b1,1'b1,1'b0,2'd0,1'b0}, // 37 R6
    '{OP_AUT,3'd2,1'b0,3'd4,1'b1,1'b1,1'b0,2'd0,1'b0}, // 38 R6 key locked
    '{OP_AUT,3'd0,1'b1,3'd4,1'b1,1'b1,1'b0,2'd1,1'b0}, // 39 R6 other key
    '{OP_AUT,3'd2,1'b1,3'd4,1'b1,1'b1,1'b0,2'd1,1'b0}, // 40 R6 ignored
    '{OP_CLR,3'd0,1'b0,3'd4,1'b1,1'b0,1'b0,2'd0,1'b0}, // 41 R1
    '{OP_PWR,3'd3,1'b1,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 42 R10 still locked
    '{OP_AUT,3'd2,1'b1,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 43 R10
    '{OP_SCC,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 44 R9
    '{OP_SCC,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 45 R9
    '{OP_SCC,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 46 R9
    '{OP_SCC,3'd0,1'b0,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}, // 47 R9
    '{OP_SCC,3'd0,1'b1,3'd3,1'b1,1'b0,1'b0,2'd0,1'b0}  // 48 R9 locked
  };

  logic        clk = 1'b0;
  logic        rst_n, sess_clr;
  logic        pw_chk, pw_wr, pw_ok, au_chk, au_ok, enc_chk, enc_ok, mac_chk, mac_ok, sc_chk;
  logic [2:0]  pw_set, zone_set;
  logic [1:0]  au_key;
  logic [23:0] sc_val;
  logic        zone_prot;
  logic        rd_grant, wr_grant, cfg_wr_grant, cmd_abort;
  logic [1:0]  sec_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sec_state_tracker u0 (
    .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr),
    .pw_chk(pw_chk), .pw_set(pw_set), .pw_wr(pw_wr), .pw_ok(pw_ok),
    .au_chk(au_chk), .au_key(au_key), .au_ok(au_ok),
    .enc_chk(enc_chk), .enc_ok(enc_ok), .mac_chk(mac_chk), .mac_ok(mac_ok),
    .sc_chk(sc_chk), .sc_val(sc_val), .zone_set(zone_set), .zone_prot(zone_prot),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .cfg_wr_grant(cfg_wr_grant),
    .sec_mode(sec_mode), .cmd_abort(cmd_abort)
  );

  task automatic idle();
    sess_clr = 1'b0; pw_chk = 1'b0; au_chk = 1'b0; enc_chk = 1'b0;
    mac_chk = 1'b0; sc_chk = 1'b0;
  endtask

  task automatic check(input string req, input string what, input logic [5:0] act,
                       input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive one pulse for one cycle, then return at the following negedge
  task automatic drive(input logic [2:0] op, input logic [2:0] arg, input logic ok);
    idle();
    case (op)
      OP_PWR, OP_PWW: begin pw_chk = 1'b1; pw_set = arg; pw_wr = (op == OP_PWW); pw_ok = ok; end
      OP_AUT: begin au_chk = 1'b1; au_key = arg[1:0]; au_ok = ok; end
      OP_ENC: begin enc_chk = 1'b1; enc_ok = ok; end
      OP_MAC: begin mac_chk = 1'b1; mac_ok = ok; end
      OP_SCC: begin sc_chk = 1'b1; sc_val = ok ? 24'hF7620B : 24'h0B62F7; end
      OP_CLR: sess_clr = 1'b1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      OP_PWR, OP_PWW: return "R2/R4/R5";
      OP_AUT:         return "R6";
      OP_ENC:         return "R7";
      OP_MAC:         return "R8";
      OP_SCC:         return "R9";
      OP_CLR:         return "R1 R10";
      default:        return "R3";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle();
    pw_set = '0; pw_wr = 1'b0; pw_ok = 1'b0; au_key = '0; au_ok = 1'b0;
    enc_ok = 1'b0; mac_ok = 1'b0; sc_val = '0; zone_set = '0; zone_prot = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      zone_set  = VEC[i].zs;
      zone_prot = VEC[i].ze;
      drive(VEC[i].op, VEC[i].arg, VEC[i].ok);
      check(req_of(VEC[i].op), $sformatf("row %0d {rd,wr,mode,cfg,abort}", i),
            {rd_grant, wr_grant, sec_mode, cfg_wr_grant, 1'b0},
            {VEC[i].rd, VEC[i].wr, VEC[i].md, VEC[i].cfg, 1'b0});
    end

    // R1: asynchronous reset state
    zone_set = 3'd3; zone_prot = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "during reset", {rd_grant, wr_grant, sec_mode, cfg_wr_grant, cmd_abort}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after reset", {rd_grant, wr_grant, sec_mode, cfg_wr_grant, cmd_abort}, 6'b0);

    // R10: power-on reset unlocks set 3 and key 2
    drive(OP_PWR, 3'd3, 1'b1);
    check("R10", "set 3 after reset", {4'b0, rd_grant, wr_grant}, {4'b0, 2'b10});
    drive(OP_AUT, 3'd2, 1'b1);
    check("R10", "key 2 after reset", {4'b0, sec_mode}, {4'b0, 2'd1});

    // R8: mismatch from authenticated mode
    drive(OP_MAC, 3'd0, 1'b0);
    check("R8", "abort from auth {mode,abort}", {3'b0, sec_mode, cmd_abort}, {3'b0, 2'd0, 1'b1});
    drive(OP_NOP, 3'd0, 1'b0);
    check("R8", "abort one cycle", {5'b0, cmd_abort}, 6'b0);

    // R8: mismatch in standard mode has no effect
    drive(OP_MAC, 3'd0, 1'b0);
    check("R8", "std mismatch {mode,abort}", {3'b0, sec_mode, cmd_abort}, 6'b0);

    // R8: mismatch from encrypted mode
    drive(OP_AUT, 3'd2, 1'b1);
    drive(OP_ENC, 3'd0, 1'b1);
    check("R7", "enc from auth", {4'b0, sec_mode}, {4'b0, 2'd2});
    drive(OP_MAC, 3'd0, 1'b0);
    check("R8", "abort from enc {mode,abort}", {3'b0, sec_mode, cmd_abort}, {3'b0, 2'd0, 1'b1});

    // R6: failed authentication drops encryption
    drive(OP_AUT, 3'd1, 1'b1);
    drive(OP_ENC, 3'd0, 1'b1);
    drive(OP_AUT, 3'd1, 1'b0);
    check("R6", "fail from enc", {4'b0, sec_mode}, 6'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule